// File: doc/BRIEF.md
# Carry-Free Branch Condition Evaluator

This unit decides, within a single cycle, whether a conditional branch is taken. Its decision logic never uses an adder or subtractor, so no carry chain lies on the decision path. The caller presents two register operands and a 3-bit branch kind, and the unit returns one taken flag.

Two kinds compare the operands with each other, for equality and for inequality. These are decided by a bitwise XOR followed by an all-zero reduction. Four kinds compare the first operand against zero, using only its sign bit and a zero test of its remaining bits. The second operand plays no part in those four kinds.

No branch kind compares two registers by magnitude. For that, software uses the separate set-less-than path. This path is off the branch path and does use a subtractor. It returns 1 in bit 0 when the first operand is below the second, with signed or unsigned ordering chosen by one control bit, and 0 otherwise. Software then branches on that value being zero or nonzero.

The block is purely combinational and has no state machine. It has no clock, no reset and no states or transitions.

Top module: `brc_eval`

## Requirements
- R1: Kind code 0 (equal) sets `br_taken` exactly when every bit of `rs_val` matches `rt_val`.
- R2: Kind code 1 (not equal) sets `br_taken` exactly when at least one bit differs; for any operand pair it is the opposite of the result for code 0.
- R3: Kind code 2 (at most zero) sets `br_taken` when `rs_val`, read as two's complement, is negative or zero.
- R4: Kind code 3 (above zero) sets `br_taken` when the sign bit (bit DW-1) of `rs_val` is clear and at least one other bit is set.
- R5: Kind code 4 (below zero) sets `br_taken` exactly when bit DW-1 of `rs_val` is 1.
- R6: Kind code 5 (at least zero) sets `br_taken` exactly when bit DW-1 of `rs_val` is 0.
- R7: Kind codes 6 and 7 never set `br_taken`, whatever the operands.
- R8: For kind codes 2 to 5, the value of `rt_val` has no effect on `br_taken`.
- R9: With `slt_unsigned` = 0, bit 0 of `slt_out` is 1 exactly when `rs_val` < `rt_val` as two's-complement numbers.
- R10: With `slt_unsigned` = 1, bit 0 of `slt_out` is 1 exactly when `rs_val` < `rt_val` as unsigned numbers.
- R11: Bits DW-1 down to 1 of `slt_out` are always 0, and equal operands always give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_val | input | DW | First operand; the only operand used by the zero tests |
| rt_val | input | DW | Second operand for the equality kinds and for set-less-than |
| br_kind | input | 3 | Branch kind: 0 eq, 1 ne, 2 lez, 3 gtz, 4 ltz, 5 gez, 6 and 7 reserved |
| slt_unsigned | input | 1 | Selects unsigned (1) or signed (0) ordering for set-less-than |
| br_taken | output | 1 | Branch decision for the presented kind |
| slt_out | output | DW | Set-less-than result, 0 or 1 |

## Verification
At DW = 4, every operand pair is swept against every kind code and both ordering modes. This covers each sign, zero and wrap pattern in full. In particular, it separates signed from unsigned ordering wherever only the top bit differs, and it separates the at-most-zero test from the below-zero test when the operand is exactly zero. At DW = 32, the unit is driven with a cross product of boundary values: zero, one, all ones, the most negative value, the most positive value, and their neighbours. This exposes errors in bit position and reduction width. Random pairs are added on top of the boundary values, including pairs that differ in a single bit, to catch an XOR reduction that misses a bit. For the zero tests, each check is repeated with a changed `rt_val` to show that the second operand has no influence.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [2:0] {
        BR_EQ   = 3'd0,
        BR_NE   = 3'd1,
        BR_LEZ  = 3'd2,
        BR_GTZ  = 3'd3,
        BR_LTZ  = 3'd4,
        BR_GEZ  = 3'd5,
        BR_RSV6 = 3'd6,
        BR_RSV7 = 3'd7
    } br_kind_e;
endpackage

// File: rtl/brc_match_unit.sv
// Two-operand equality through XOR and an OR reduction, with no carry.
module brc_match_unit #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    output logic          same
);
    logic [DW-1:0] diff_bits;

    always_comb begin
        diff_bits = op_a ^ op_b;
        same      = ~(|diff_bits);
    end

    always_comb begin
        // R1
        if (same) begin
            match_sign_chk: assert (op_a[DW-1] == op_b[DW-1] && op_a[0] == op_b[0]);
        end
    end
endmodule

// File: rtl/brc_zero_unit.sv
// Sign bit plus a zero test of the remaining bits of one operand.
module brc_zero_unit #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] op_a,
    output logic          lez,
    output logic          gtz,
    output logic          ltz,
    output logic          gez
);
    localparam int MSB = DW - 1;

    logic sign_bit;
    logic low_clear;

    always_comb begin
        sign_bit  = op_a[MSB];
        low_clear = ~(|op_a[MSB-1:0]);
        ltz       = sign_bit;
        gez       = ~sign_bit;
        lez       = sign_bit | low_clear;
        gtz       = ~sign_bit & ~low_clear;
    end

    always_comb begin
        // R3 R6
        if (lez && gez) begin
            zero_both_chk: assert (op_a == '0);
        end
    end
endmodule

// File: rtl/brc_slt_unit.sv
// Set-less-than: uses a subtractor, but sits beside the branch path.
module brc_slt_unit #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          uns,
    output logic [DW-1:0] result
);
    localparam int EW = DW + 1;

    logic [EW-1:0] ext_a;
    logic [EW-1:0] ext_b;
    logic [EW-1:0] delta;

    always_comb begin
        ext_a  = {~uns & op_a[DW-1], op_a};
        ext_b  = {~uns & op_b[DW-1], op_b};
        delta  = ext_a - ext_b;
        result = {{(DW-1){1'b0}}, delta[EW-1]};
    end

    always_comb begin
        // R11
        if (op_a == op_b) begin
            slt_equal_chk: assert (result == '0);
        end
    end
endmodule

// File: rtl/brc_eval.sv
module brc_eval
    import brc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] rs_val,
    input  logic [DW-1:0] rt_val,
    input  logic [2:0]    br_kind,
    input  logic          slt_unsigned,
    output logic          br_taken,
    output logic [DW-1:0] slt_out
);
    logic     eq_hit;
    logic     lez_hit;
    logic     gtz_hit;
    logic     ltz_hit;
    logic     gez_hit;
    br_kind_e kind;

    brc_match_unit #(.DW(DW)) u_match (
        .op_a (rs_val),
        .op_b (rt_val),
        .same (eq_hit)
    );

    brc_zero_unit #(.DW(DW)) u_zero (
        .op_a (rs_val),
        .lez  (lez_hit),
        .gtz  (gtz_hit),
        .ltz  (ltz_hit),
        .gez  (gez_hit)
    );

    brc_slt_unit #(.DW(DW)) u_slt (
        .op_a   (rs_val),
        .op_b   (rt_val),
        .uns    (slt_unsigned),
        .result (slt_out)
    );

    always_comb begin
        kind = br_kind_e'(br_kind);
        unique case (kind)
            BR_EQ:   br_taken = eq_hit;
            BR_NE:   br_taken = ~eq_hit;
            BR_LEZ:  br_taken = lez_hit;
            BR_GTZ:  br_taken = gtz_hit;
            BR_LTZ:  br_taken = ltz_hit;
            BR_GEZ:  br_taken = gez_hit;
            default: br_taken = 1'b0;
        endcase
    end

    always_comb begin
        // R7
        if (br_kind[2:1] == 2'b11) begin
            reserved_kind_chk: assert (!br_taken);
        end
        // R11
        slt_upper_chk: assert (slt_out[DW-1:1] == '0);
    end
endmodule

// File: tb/brc_eval_tb.sv
module brc_eval_tb;
    localparam int W = 32;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0]  a, b;
    logic [2:0]    k;
    logic          u;
    logic          tk;
    logic [W-1:0]  so;
    logic [SW-1:0] sa, sb;
    logic [2:0]    sk;
    logic          su;
    logic          stk;
    logic [SW-1:0] sso;

    int checks = 0;
    int errors = 0;

    brc_eval #(.DW(W)) u_dut (
        .rs_val(a), .rt_val(b), .br_kind(k), .slt_unsigned(u),
        .br_taken(tk), .slt_out(so)
    );

    brc_eval #(.DW(SW)) u_small (
        .rs_val(sa), .rt_val(sb), .br_kind(sk), .slt_unsigned(su),
        .br_taken(stk), .slt_out(sso)
    );

    function automatic logic ref_taken(input logic [2:0] kk, input logic signed [63:0] x,
                                       input logic signed [63:0] y);
        case (kk)
            3'd0: return x == y;
            3'd1: return x != y;
            3'd2: return x <= 0;
            3'd3: return x > 0;
            3'd4: return x < 0;
            3'd5: return x >= 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] kk);
        case (kk)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h k=%0d u=%0b)",
                     req, act, exp, a, b, k, u);
        end
    endtask

    task automatic run_wide(input logic [W-1:0] x, input logic [W-1:0] y);
        logic signed [63:0] xs, ys;
        logic ref_zero;
        xs = {{32{x[W-1]}}, x};
        ys = {{32{y[W-1]}}, y};
        a = x; b = y;
        for (int kk = 0; kk < 8; kk++) begin
            k = 3'(kk);
            #1;
            check(tag_of(k), 64'(tk), 64'(ref_taken(k, xs, ys)));
            if (kk >= 2 && kk <= 5) begin
                ref_zero = ref_taken(k, xs, 64'sd0);
                b = ~y;
                #1;
                check("R8", 64'(tk), 64'(ref_zero));
                b = y;
            end
        end
        u = 1'b0; #1;
        check("R9", 64'(so), 64'(xs < ys));
        u = 1'b1; #1;
        check("R10", 64'(so), 64'({32'd0, x} < {32'd0, y}));
    endtask

    logic [W-1:0] edges [10];

    initial begin
        a = '0; b = '0; k = 3'd0; u = 1'b0;
        sa = '0; sb = '0; sk = 3'd0; su = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 64'(tk), 64'd1);
        check("R11", 64'(so), 64'd0);

        // exhaustive sweep of the narrow configuration
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int kk = 0; kk < 8; kk++) begin
                    logic signed [63:0] xs, ys;
                    sa = 4'(x); sb = 4'(y); sk = 3'(kk);
                    xs = 64'(signed'(4'(x)));
                    ys = 64'(signed'(4'(y)));
                    #1;
                    checks++;
                    if (stk !== ref_taken(sk, xs, ys)) begin
                        errors++;
                        $display("FAIL %s: actual %0b expected %0b (narrow a=%h b=%h k=%0d)",
                                 tag_of(sk), stk, ref_taken(sk, xs, ys), sa, sb, sk);
                    end
                end
                su = 1'b0; #1;
                checks++;
                if (sso !== 4'(signed'(4'(x)) < signed'(4'(y)))) begin
                    errors++;
                    $display("FAIL R9: actual %h expected %h (narrow a=%h b=%h)",
                             sso, 4'(signed'(4'(x)) < signed'(4'(y))), sa, sb);
                end
                su = 1'b1; #1;
                checks++;
                if (sso !== 4'(x < y)) begin
                    errors++;
                    $display("FAIL R10: actual %h expected %h (narrow a=%h b=%h)",
                             sso, 4'(x < y), sa, sb);
                end
            end
            @(negedge clk);
        end

        // boundary cross product at full width
        edges[0] = 32'h0000_0000; edges[1] = 32'h0000_0001;
        edges[2] = 32'hFFFF_FFFF; edges[3] = 32'h8000_0000;
        edges[4] = 32'h7FFF_FFFF; edges[5] = 32'h8000_0001;
        edges[6] = 32'hFFFF_FFFE; edges[7] = 32'h0000_0002;
        edges[8] = 32'h4000_0000; edges[9] = 32'h7FFF_FFFE;
        for (int i = 0; i < 10; i++) begin
            for (int j = 0; j < 10; j++) begin
                run_wide(edges[i], edges[j]);
            end
            @(negedge clk);
        end

        // random pairs and single-bit-apart pairs
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] r;
            r = $urandom;
            run_wide(r, $urandom);
            run_wide(r, r ^ (32'd1 << ($urandom % 32)));
            run_wide(r, r);
            @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule